// File: doc/BRIEF.md
# Phase-Accumulating Tone Synthesizer with Byte-Staged Configuration

This block is a direct digital synthesis core. A 32-bit phase accumulator advances by a tuning word on every system clock, so its most significant bit toggles as a square wave. The output frequency is the tuning word times the clock rate divided by 2^32. For example, with a 180 MHz clock, the word 0x016C16C1 yields roughly 1 MHz, 0x0E38E38E yields 10 MHz and 0x00123456 yields about 50 kHz. The top bits of the accumulator are also brought out as a phase value.

The configuration arrives over a narrow byte port: an 8-bit data bus, a word strobe and an update strobe, all asynchronous to the system clock. Both strobes are synchronized and edge-detected, so they may arrive at any time relative to the clock.
- Each rising edge of the word strobe places one byte into a five-byte holding area. The first byte is the control byte, and the next four form the tuning word, most significant byte first.
- A rising edge of the update strobe copies the whole holding area into the working registers at once.

The bit 0 of the active control byte is brought out as a multiplier-enable flag. The block has no multiplier of its own.

Top module: `dds_core`

## Requirements
- R1: While `rst` is high, at the next clock edge the accumulator, the active control byte, the active tuning word, the byte position and the holding area all become zero. `phase_out`, `square_out`, `ctrl_out` and `mult_en` then read 0, and the phase stays at 0.
- R2: Each rising edge of `cfg_wclk` stores `cfg_data` into the next byte of the holding area. Byte 0 is the control byte. Bytes 1 to 4 form the tuning word, with byte 1 as bits 31:24 and byte 4 as bits 7:0.
- R3: Bytes written to the holding area do not change `ctrl_out` or the accumulator step until an update strobe arrives.
- R4: Suppose `cfg_update` is driven high shortly after a clock edge. Then `ctrl_out` takes the new control byte on the third following clock edge, and the new tuning word is first added on the fourth.
- R5: On every clock edge the accumulator adds the active tuning word modulo 2^32. `phase_out` is the top PHASE_W bits of the accumulator.
- R6: `square_out` is the accumulator MSB. For tuning words below 2^31, it rises once for every crossing of the half-scale point.
- R7: A sixth byte written without an update in between wraps to byte 0 and replaces the control byte.
- R8: An update strobe returns the byte position to byte 0. Bytes not rewritten since then keep their earlier values.
- R9: A reset in the middle of a load discards the partial sequence. The next byte written goes to byte 0.
- R10: `cfg_data` is taken only at the rising edge of `cfg_wclk`. Holding the strobe high for many cycles stores exactly one byte, and data changes while the strobe is low have no effect.
- R11: `mult_en` equals bit 0 of the active control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data | input | 8 | Configuration byte bus |
| cfg_wclk | input | 1 | Byte strobe; asynchronous, rising edge stores a byte |
| cfg_update | input | 1 | Update strobe; asynchronous, rising edge activates the held bytes |
| phase_out | output | PHASE_W | Top bits of the phase accumulator |
| square_out | output | 1 | Accumulator MSB, square-wave output |
| ctrl_out | output | 8 | Active control byte |
| mult_en | output | 1 | Bit 0 of the active control byte |

## Verification
The latency of a strobe is defined from the first clock edge after its rising edge.
- A strobe passes through two synchronizer stages and one edge-detect register. Its effect therefore lands on the third clock edge: that is when `ctrl_out` changes.
- The new tuning word first moves the phase on the fourth clock edge.

The bench drives its inputs at falling edges and records the phase at each of the next four falling edges. It expects the old control byte and the old step up to the second sample, and the new values from the third and fourth samples. Long windows check the step of the full-width phase on every cycle. Square-wave edge counts are compared with the number of half-scale crossings computed from the starting phase and the tuning word.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int BYTE_W        = 8;
    localparam int N_BYTES       = 5;
    localparam int FTW_BYTES     = N_BYTES - 1;
    localparam int ACC_W         = FTW_BYTES * BYTE_W;
    localparam int PTR_W         = $clog2(N_BYTES);
    localparam int CTRL_MULT_BIT = 0;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ACC_W-1:0]  ftw_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    // Working configuration: control byte above the tuning word
    typedef struct packed {
        byte_t ctrl;
        ftw_t  ftw;
    } cfg_word_t;

    localparam ptr_t LAST_PTR = ptr_t'(N_BYTES - 1);

    // Byte position after a store: wraps from the last byte back to byte 0
    function automatic ptr_t advance_ptr(ptr_t p);
        return (p == LAST_PTR) ? '0 : ptr_t'(p + 1'b1);
    endfunction

    // Bit offset of holding byte idx (1..FTW_BYTES) inside the tuning word
    function automatic int ftw_offset(int idx);
        return (FTW_BYTES - idx) * BYTE_W;
    endfunction

endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dds_cfg_loader.sv
module dds_cfg_loader
    import dds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_t     data_i,
    input  logic      wr_i,
    input  logic      upd_i,
    output cfg_word_t active_o,
    output ptr_t      ptr_o
);

    byte_t     hold_q [N_BYTES];
    ptr_t      ptr_q;
    cfg_word_t active_q;
    cfg_word_t held;

    // Assemble the holding area into the working layout
    always_comb begin
        held.ctrl = hold_q[0];
        held.ftw  = '0;
        for (int i = 1; i < N_BYTES; i++) begin
            held.ftw[ftw_offset(i) +: BYTE_W] = hold_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            active_q <= '0;
            for (int i = 0; i < N_BYTES; i++) begin
                hold_q[i] <= '0;
            end
        end else begin
            if (wr_i) begin
                hold_q[ptr_q] <= data_i;
            end
            if (upd_i) begin
                ptr_q    <= '0;
                active_q <= held;
            end else if (wr_i) begin
                ptr_q <= advance_ptr(ptr_q);
            end
        end
    end

    assign active_o = active_q;
    assign ptr_o    = ptr_q;

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ftw_t step_i,
    output ftw_t acc_o
);

    ftw_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + step_i;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PHASE_W     = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         cfg_data,
    input  logic               cfg_wclk,
    input  logic               cfg_update,
    output logic [PHASE_W-1:0] phase_out,
    output logic               square_out,
    output logic [7:0]         ctrl_out,
    output logic               mult_en
);

    logic      wr_pulse;
    logic      upd_pulse;
    cfg_word_t active_cfg;
    ptr_t      cfg_ptr;
    ftw_t      acc_val;

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cfg_wclk),
        .rise_o   (wr_pulse)
    );

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cfg_update),
        .rise_o   (upd_pulse)
    );

    dds_cfg_loader u_loader (
        .clk      (clk),
        .rst      (rst),
        .data_i   (cfg_data),
        .wr_i     (wr_pulse),
        .upd_i    (upd_pulse),
        .active_o (active_cfg),
        .ptr_o    (cfg_ptr)
    );

    dds_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .step_i (active_cfg.ftw),
        .acc_o  (acc_val)
    );

    assign phase_out  = acc_val[ACC_W-1 -: PHASE_W];
    assign square_out = acc_val[ACC_W-1];
    assign ctrl_out   = active_cfg.ctrl;
    assign mult_en    = active_cfg.ctrl[CTRL_MULT_BIT];

endmodule

// File: rtl/dds_core_checker.sv
module dds_core_checker
    import dds_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_pulse,
    input logic  upd_pulse,
    input ptr_t  ptr,
    input ftw_t  acc,
    input ftw_t  ftw,
    input byte_t ctrl
);

    logic armed_q;
    logic past_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b1;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= armed_q;
        end
    end

    // R1: one cycle after reset, all state is cleared
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !past_ok_q) |-> (acc == '0 && ctrl == '0 && ftw == '0 && ptr == '0));

    // R5: the accumulator steps by the active tuning word
    a_r5_acc_step: assert property (@(posedge clk) disable iff (rst)
        past_ok_q |-> (acc == ftw_t'($past(acc) + $past(ftw))));

    // R3: the active configuration only moves on an update
    a_r3_hold_until_update: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$past(upd_pulse)) |-> ($stable(ctrl) && $stable(ftw)));

    // R2: byte position stays inside the holding area
    a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_PTR);

    // R8: update returns the byte position to zero
    a_r8_upd_ptr_zero: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && $past(upd_pulse)) |-> (ptr == '0));

    // R7: a store at the last byte wraps to byte 0
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && $past(wr_pulse) && !$past(upd_pulse) && $past(ptr) == LAST_PTR)
        |-> (ptr == '0));

    // R10: without a strobe edge the byte position holds
    a_r10_ptr_idle: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$past(wr_pulse) && !$past(upd_pulse)) |-> $stable(ptr));

    // R10: strobe edges are single-cycle pulses
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

endmodule

bind dds_core dds_core_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_pulse  (wr_pulse),
    .upd_pulse (upd_pulse),
    .ptr       (cfg_ptr),
    .acc       (acc_val),
    .ftw       (active_cfg.ftw),
    .ctrl      (active_cfg.ctrl)
);

// File: tb/dds_core_bench.sv
module dds_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cfg_data = '0;
    logic          cfg_wclk = 1'b0;
    logic          cfg_update = 1'b0;
    logic [PW-1:0] phase_out;
    logic          square_out;
    logic [7:0]    ctrl_out;
    logic          mult_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the configuration path, built from R2, R7, R8, R9
    logic [7:0]  hold_m [5];
    int          ptr_m;
    logic [7:0]  cur_ctrl;
    logic [31:0] cur_ftw;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_core #(.SYNC_STAGES(2), .PHASE_W(PW)) u_dds_core (
        .clk        (clk),
        .rst        (rst),
        .cfg_data   (cfg_data),
        .cfg_wclk   (cfg_wclk),
        .cfg_update (cfg_update),
        .phase_out  (phase_out),
        .square_out (square_out),
        .ctrl_out   (ctrl_out),
        .mult_en    (mult_en)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] held_ftw();
        return {hold_m[1], hold_m[2], hold_m[3], hold_m[4]};
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 5; i++) hold_m[i] = '0;
        ptr_m    = 0;
        cur_ctrl = '0;
        cur_ftw  = '0;
    endtask

    task automatic send_byte_hold(input logic [7:0] b, input int high_cycles);
        cfg_data = b;
        cfg_wclk = 1'b1;
        repeat (high_cycles) @(negedge clk);
        cfg_wclk = 1'b0;
        repeat (4) @(negedge clk);
        hold_m[ptr_m] = b;
        ptr_m = (ptr_m == 4) ? 0 : ptr_m + 1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_byte_hold(b, 4);
    endtask

    task automatic load_all(input logic [7:0] c, input logic [31:0] w);
        send_byte(c);
        send_byte(w[31:24]);
        send_byte(w[23:16]);
        send_byte(w[15:8]);
        send_byte(w[7:0]);
    endtask

    // R3/R4 timing: samples at the four falling edges after the strobe rises
    task automatic pulse_update();
        logic [31:0] p1, p2, p3, p4;
        logic [7:0]  new_ctrl;
        logic [31:0] new_ftw;
        new_ctrl = hold_m[0];
        new_ftw  = held_ftw();
        cfg_update = 1'b1;
        @(negedge clk); p1 = phase_out;
        @(negedge clk); p2 = phase_out;
        check(ctrl_out == cur_ctrl, "R3 ctrl before update lands", ctrl_out, cur_ctrl);
        @(negedge clk); p3 = phase_out;
        check(ctrl_out == new_ctrl, "R4 ctrl on third edge", ctrl_out, new_ctrl);
        check(mult_en == new_ctrl[0], "R11 mult_en follows ctrl bit 0", mult_en, new_ctrl[0]);
        check(32'(p3 - p2) == cur_ftw, "R3 old step on third edge", 32'(p3 - p2), cur_ftw);
        check(32'(p2 - p1) == cur_ftw, "R3 old step before update", 32'(p2 - p1), cur_ftw);
        @(negedge clk); p4 = phase_out;
        check(32'(p4 - p3) == new_ftw, "R4 new step on fourth edge", 32'(p4 - p3), new_ftw);
        cfg_update = 1'b0;
        repeat (4) @(negedge clk);
        cur_ctrl = new_ctrl;
        cur_ftw  = new_ftw;
        ptr_m    = 0;
    endtask

    task automatic run_window(input int n, input string tag);
        logic [31:0] prev;
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            prev = phase_out;
            @(negedge clk);
            if (phase_out != 32'(prev + cur_ftw)) bad++;
        end
        check(bad == 0, tag, 64'(bad), 64'd0);
        check(ctrl_out == cur_ctrl, "R3 ctrl steady in window", ctrl_out, cur_ctrl);
    endtask

    task automatic freq_check(input int n);
        logic [63:0] p0, hi, lo, exp_edges;
        logic        prev_sq;
        int          edges;
        p0 = 64'(phase_out);
        prev_sq = square_out;
        edges = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (square_out && !prev_sq) edges++;
            prev_sq = square_out;
        end
        hi = (p0 + 64'(n) * 64'(cur_ftw) + 64'h8000_0000) >> 32;
        lo = (p0 + 64'h8000_0000) >> 32;
        exp_edges = hi - lo;
        check(64'(edges) == exp_edges, "R6 square rising edges", 64'(edges), exp_edges);
        check(square_out == phase_out[31], "R6 square is MSB", square_out, phase_out[31]);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        rst = 1'b0;
        clear_model();
        check(phase_out == '0, "R1 phase cleared", phase_out, 0);
        check(ctrl_out == '0 && mult_en == 1'b0, "R1 ctrl cleared", ctrl_out, 0);
        check(square_out == 1'b0, "R1 square cleared", square_out, 0);
        run_window(8, "R1 phase idle after reset");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] words [7];
        logic [7:0]  ctrls [7];
        words = '{32'h016C16C1, 32'h0E38E38E, 32'h00123456, 32'h00000001,
                  32'hFFFFFFFF, 32'h80000000, 32'h12345678};
        ctrls = '{8'h01, 8'h00, 8'h81, 8'h3C, 8'h01, 8'hFE, 8'h55};
        clear_model();
        @(negedge clk);
        do_reset(5);

        // R2, R3, R4, R5, R6 over a sweep of tuning words
        for (int k = 0; k < 7; k++) begin
            load_all(ctrls[k], words[k]);
            run_window(6, "R3 staged bytes not yet active");
            pulse_update();
            check(ctrl_out == ctrls[k], "R2 control byte first", ctrl_out, ctrls[k]);
            check(cur_ftw == words[k], "R2 word order model", cur_ftw, words[k]);
            run_window(32, "R5 phase step per clock");
            if (words[k] < 32'h8000_0000) freq_check(2000);
        end

        // R7: sixth byte wraps to the control position
        load_all(8'hA0, 32'h11223344);
        send_byte(8'h5C);
        pulse_update();
        check(ctrl_out == 8'h5C, "R7 sixth byte replaces control", ctrl_out, 8'h5C);
        run_window(16, "R7 word kept after wrap");

        // R8: update rewinds the pointer; untouched bytes persist
        send_byte(8'h03);
        send_byte(8'h9A);
        pulse_update();
        check(cur_ftw == 32'h9A223344, "R8 partial load model", cur_ftw, 32'h9A223344);
        run_window(16, "R8 partial word active");
        load_all(8'h02, 32'h01020304);
        pulse_update();
        check(ctrl_out == 8'h02, "R8 pointer back at byte 0", ctrl_out, 8'h02);
        run_window(16, "R8 full reload step");

        // R10: junk while strobe low, long strobe stores one byte
        for (int j = 0; j < 12; j++) begin
            cfg_data = 8'(j * 37 + 11);
            @(negedge clk);
        end
        send_byte_hold(8'h07, 20);
        send_byte_hold(8'h00, 15);
        send_byte(8'h40);
        send_byte(8'h00);
        send_byte(8'h00);
        pulse_update();
        check(ctrl_out == 8'h07, "R10 long strobe one byte ctrl", ctrl_out, 8'h07);
        check(cur_ftw == 32'h00400000, "R10 word model", cur_ftw, 32'h00400000);
        run_window(16, "R10 step after long strobes");
        freq_check(1000);

        // R9: reset in the middle of a load
        send_byte(8'hEE);
        send_byte(8'hDD);
        do_reset(3);
        load_all(8'h01, 32'h0E38E38E);
        pulse_update();
        check(ctrl_out == 8'h01, "R9 load after mid reset", ctrl_out, 8'h01);
        run_window(16, "R9 step after mid reset");
        freq_check(1800);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule